// File: doc/BRIEF.md
# Paired-Issue Interlock Stall Calculator

This block sits beside the issue stage of a pipeline that issues two instructions in one cycle. It receives a description of the older and the younger instruction of the pair. For each instruction it gets a class code, up to two destination register tags and up to three source register tags, each with its own valid bit. For the older instruction it also gets a base latency and a write-back latency for each destination. It then works out how many cycles the younger instruction has to wait before it can go. Register tags are five bits wide by default. Unused operand slots are marked invalid and never take part in a comparison.

Three kinds of hazard are looked for. The first is the younger instruction reading what the older one writes (RAW). The second is both instructions writing the same register (WAW), which counts only when an FP-execute instruction is followed by a load/store. The third is the younger instruction writing what the older one reads (WAR). Each hazard has its own stall rule. The RAW latency is corrected for three pairings: an FP result stored straight away, a load that feeds a shift count, and a short FP write that feeds a double-precision, inner-product or vector-transform consumer. The result is the largest of the individual stalls together with a code naming the hazard that set it. It is registered one cycle after the request.

Top module: `pair_stall_calc`

## Requirements
- R1: A request presented with `in_valid` high at a rising edge produces `out_valid` high, with its result, right after that edge; a cycle with `in_valid` low is followed by `out_valid` low, `stall_cycles` 0 and `hazard_kind` 0. Reset drives all three outputs to 0.
- R2: If a valid older destination tag equals a valid younger source tag (RAW), the stall is the older base latency `old_lat`, as corrected by R7 to R9.
- R3: On a WAW match where the older class is divide/square-root (class 3), the stall is the largest write-back latency over all valid older destinations, minus 1.
- R4: On a WAW match where the older class is any other FP-execute class (4 to 7), the stall is that largest write-back latency minus 2, clamped at 0.
- R5: WAW is considered only when the older class is FP-execute (3 to 7) and the younger class is load/store (1 memory, 2 load); any other pairing of equal destinations gives no stall.
- R6: If a valid younger destination equals a valid older source (WAR), the stall is 5 when the older class is vector transform (4), 2 when it is FP arithmetic (6) with `old_flags` bit 0 (double) set, and 0 otherwise.
- R7: When the older class is FP-execute and the younger sets `yng_flags` bit 1 (FP store) and has a RAW match, the RAW latency is one less.
- R8: When the older class is load (2), the younger sets `yng_flags` bit 2 (shift by register) and younger source slot 0 matches an older destination, the RAW latency is one more; a match in any other slot gives no increase.
- R9: When the older instruction sets `old_flags` bit 1 (writes an FP register) and has `old_lat` below 2, and the younger is double precision (`yng_flags` bit 0), inner product (class 5) or vector transform (class 4), the RAW latency is raised to 2.
- R10: When several hazards apply, the stall is their maximum, and `hazard_kind` gives the winner (1 RAW, 2 WAW, 3 WAR; RAW before WAW before WAR on ties). A zero stall always reports code 0.
- R11: An operand slot whose valid bit is low never matches, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pair description valid this cycle |
| old_cls | input | 3 | Older class: 0 integer, 1 memory, 2 load, 3 divide/sqrt, 4 vector transform, 5 inner product, 6 FP arithmetic, 7 other FP |
| old_lat | input | LAT_W | Older base latency |
| old_dst_vld | input | NDST | Older destination slot valid bits |
| old_dst_tag | input | NDST*TAG_W | Older destination tags, slot 0 in the low bits |
| old_dst_wb | input | NDST*LAT_W | Older write-back latency per destination |
| old_src_vld | input | NSRC | Older source slot valid bits |
| old_src_tag | input | NSRC*TAG_W | Older source tags |
| old_flags | input | 2 | bit 0 double precision, bit 1 writes FP register |
| yng_cls | input | 3 | Younger class, same encoding |
| yng_dst_vld | input | NDST | Younger destination slot valid bits |
| yng_dst_tag | input | NDST*TAG_W | Younger destination tags |
| yng_src_vld | input | NSRC | Younger source slot valid bits |
| yng_src_tag | input | NSRC*TAG_W | Younger source tags, slot 0 is the shift count |
| yng_flags | input | 3 | bit 0 double precision, bit 1 FP store, bit 2 shift by register |
| out_valid | output | 1 | Result valid |
| stall_cycles | output | LAT_W+1 | Cycles the younger instruction waits |
| hazard_kind | output | 2 | 0 none, 1 RAW, 2 WAW, 3 WAR |

## Verification
The assertions assume that each pair description is complete and stable in the cycle `in_valid` is high. They also assume that the class codes and flags are consistent with one another, so that a WAR result can be traced back to an older vector-transform or double-precision arithmetic instruction. The stimulus fills every field from a cleared default before each request, so unused slots are always invalid. It varies one condition at a time around each rule, so every expected stall follows directly from the requirements.

// File: rtl/stall_pkg.sv
package stall_pkg;

   localparam int CLS_W      = 3;
   localparam int HAZ_W      = 2;
   localparam int OLD_FLAG_W = 2;
   localparam int YNG_FLAG_W = 3;

   // older-instruction flag positions
   localparam int OF_DBL   = 0;
   localparam int OF_FPDST = 1;

   // younger-instruction flag positions
   localparam int YF_DBL    = 0;
   localparam int YF_FSTORE = 1;
   localparam int YF_SHREG  = 2;

   typedef enum logic [CLS_W-1:0] {
      CLS_INT    = 3'd0,
      CLS_MEM    = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_FDIVSQ = 3'd3,
      CLS_FVTRF  = 3'd4,
      CLS_FINNER = 3'd5,
      CLS_FARITH = 3'd6,
      CLS_FMISC  = 3'd7
   } icls_e;

   typedef enum logic [HAZ_W-1:0] {
      HZ_NONE = 2'd0,
      HZ_RAW  = 2'd1,
      HZ_WAW  = 2'd2,
      HZ_WAR  = 2'd3
   } hazard_e;

   function automatic logic cls_is_fe(input logic [CLS_W-1:0] c);
      return c >= CLS_FDIVSQ;
   endfunction

   function automatic logic cls_is_ls(input logic [CLS_W-1:0] c);
      return (c == CLS_MEM) || (c == CLS_LOAD);
   endfunction

endpackage

// File: rtl/stall_tag_match.sv
// Compares every valid tag of side A against every valid tag of side B and
// reports, per B slot, whether any A slot hit it.
module stall_tag_match #(
   parameter int NA    = 2,
   parameter int NB    = 3,
   parameter int TAG_W = 5
) (
   input  logic [NA-1:0]       a_vld,
   input  logic [NA*TAG_W-1:0] a_tag,
   input  logic [NB-1:0]       b_vld,
   input  logic [NB*TAG_W-1:0] b_tag,
   output logic [NB-1:0]       b_hit
);

   if (NA < 1 || NB < 1 || TAG_W < 1) begin : g_bad_cfg
      $error("stall_tag_match: NA, NB and TAG_W must all be at least 1");
   end

   for (genvar j = 0; j < NB; j++) begin : g_b
      logic [NA-1:0] row;
      for (genvar i = 0; i < NA; i++) begin : g_a
         assign row[i] = a_vld[i] & b_vld[j] &
                         (a_tag[i*TAG_W +: TAG_W] == b_tag[j*TAG_W +: TAG_W]);
      end
      assign b_hit[j] = |row;
   end

endmodule

// File: rtl/stall_lat_adjust.sv
// Effective RAW latency of the older instruction after pairing corrections,
// and the longest write-back latency over its valid destinations.
module stall_lat_adjust
   import stall_pkg::*;
#(
   parameter int NDST  = 2,
   parameter int LAT_W = 5
) (
   input  logic [CLS_W-1:0]      old_cls,
   input  logic [LAT_W-1:0]      old_lat,
   input  logic [NDST-1:0]       old_dst_vld,
   input  logic [NDST*LAT_W-1:0] old_dst_wb,
   input  logic                  old_fpdst,
   input  logic [CLS_W-1:0]      yng_cls,
   input  logic                  yng_dbl,
   input  logic                  yng_fstore,
   input  logic                  yng_shreg,
   input  logic                  raw_any,
   input  logic                  raw_cnt_slot,
   output logic [LAT_W:0]        eff_lat,
   output logic [LAT_W-1:0]      wb_max
);

   localparam int SW = LAT_W + 2;

   if (NDST < 1 || LAT_W < 2) begin : g_bad_cfg
      $error("stall_lat_adjust: NDST must be >= 1 and LAT_W >= 2");
   end

   // longest write-back latency over valid destinations
   if (NDST == 1) begin : g_wb_single
      assign wb_max = old_dst_vld[0] ? old_dst_wb[LAT_W-1:0] : '0;
   end else begin : g_wb_chain
      logic [NDST:0][LAT_W-1:0] acc;
      assign acc[0] = '0;
      for (genvar k = 0; k < NDST; k++) begin : g_step
         logic [LAT_W-1:0] wb_k;
         assign wb_k       = old_dst_wb[k*LAT_W +: LAT_W];
         assign acc[k+1]   = (old_dst_vld[k] && (wb_k > acc[k])) ? wb_k : acc[k];
      end
      assign wb_max = acc[NDST];
   end

   // pairing corrections
   logic fs_cut;
   logic sh_add;
   logic dp_raise;
   logic dp_consumer;

   assign fs_cut      = cls_is_fe(old_cls) & yng_fstore & raw_any;
   assign sh_add      = (old_cls == CLS_LOAD) & yng_shreg & raw_cnt_slot;
   assign dp_consumer = yng_dbl | (yng_cls == CLS_FINNER) | (yng_cls == CLS_FVTRF);
   assign dp_raise    = old_fpdst & (old_lat < LAT_W'(2)) & dp_consumer;

   logic signed [SW-1:0] sum;
   logic        [SW-1:0] fixed;

   always_comb begin
      sum   = signed'(SW'(old_lat)) + signed'(SW'(sh_add)) - signed'(SW'(fs_cut));
      fixed = sum[SW-1] ? '0 : unsigned'(sum);
      if (dp_raise && (fixed < SW'(2))) begin
         fixed = SW'(2);
      end
      eff_lat = fixed[LAT_W:0];
   end

endmodule

// File: rtl/stall_resolve.sv
// Per-hazard stall values, maximum selection, hazard code and output register.
module stall_resolve
   import stall_pkg::*;
#(
   parameter int LAT_W    = 5,
   parameter int WAR_VTRF = 5,
   parameter int WAR_DBL  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             raw_any,
   input  logic [LAT_W:0]   eff_lat,
   input  logic             waw_any,
   input  logic [LAT_W-1:0] wb_max,
   input  logic             war_any,
   input  logic [CLS_W-1:0] old_cls,
   input  logic             old_dbl,
   input  logic [CLS_W-1:0] yng_cls,
   output logic             out_valid,
   output logic [LAT_W:0]   stall_cycles,
   output logic [HAZ_W-1:0] hazard_kind
);

   localparam int CW = LAT_W + 1;

   if (WAR_VTRF < 0 || WAR_DBL < 0 ||
       WAR_VTRF >= (1 << CW) || WAR_DBL >= (1 << CW)) begin : g_bad_cfg
      $error("stall_resolve: WAR stall constants must fit the stall count");
   end

   logic          waw_ok;
   logic [CW-1:0] waw_cut;
   logic [CW-1:0] wb_ext;
   logic [CW-1:0] raw_val;
   logic [CW-1:0] waw_val;
   logic [CW-1:0] war_val;
   logic [CW-1:0] best;
   hazard_e       kind_d;

   assign waw_ok  = waw_any & cls_is_fe(old_cls) & cls_is_ls(yng_cls);
   assign waw_cut = (old_cls == CLS_FDIVSQ) ? CW'(1) : CW'(2);
   assign wb_ext  = {1'b0, wb_max};

   always_comb begin
      raw_val = raw_any ? eff_lat : '0;

      waw_val = '0;
      if (waw_ok && (wb_ext > waw_cut)) begin
         waw_val = wb_ext - waw_cut;
      end

      war_val = '0;
      if (war_any) begin
         if (old_cls == CLS_FVTRF) begin
            war_val = CW'(WAR_VTRF);
         end else if ((old_cls == CLS_FARITH) && old_dbl) begin
            war_val = CW'(WAR_DBL);
         end
      end

      best   = raw_val;
      kind_d = HZ_RAW;
      if (waw_val > best) begin
         best   = waw_val;
         kind_d = HZ_WAW;
      end
      if (war_val > best) begin
         best   = war_val;
         kind_d = HZ_WAR;
      end
      if (best == '0) begin
         kind_d = HZ_NONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         stall_cycles <= '0;
         hazard_kind  <= HZ_NONE;
      end else if (in_valid) begin
         out_valid    <= 1'b1;
         stall_cycles <= best;
         hazard_kind  <= kind_d;
      end else begin
         out_valid    <= 1'b0;
         stall_cycles <= '0;
         hazard_kind  <= HZ_NONE;
      end
   end

endmodule

// File: rtl/pair_stall_calc.sv
module pair_stall_calc
   import stall_pkg::*;
#(
   parameter int NSRC     = 3,
   parameter int NDST     = 2,
   parameter int TAG_W    = 5,
   parameter int LAT_W    = 5,
   parameter int WAR_VTRF = 5,
   parameter int WAR_DBL  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [CLS_W-1:0]      old_cls,
   input  logic [LAT_W-1:0]      old_lat,
   input  logic [NDST-1:0]       old_dst_vld,
   input  logic [NDST*TAG_W-1:0] old_dst_tag,
   input  logic [NDST*LAT_W-1:0] old_dst_wb,
   input  logic [NSRC-1:0]       old_src_vld,
   input  logic [NSRC*TAG_W-1:0] old_src_tag,
   input  logic [OLD_FLAG_W-1:0] old_flags,
   input  logic [CLS_W-1:0]      yng_cls,
   input  logic [NDST-1:0]       yng_dst_vld,
   input  logic [NDST*TAG_W-1:0] yng_dst_tag,
   input  logic [NSRC-1:0]       yng_src_vld,
   input  logic [NSRC*TAG_W-1:0] yng_src_tag,
   input  logic [YNG_FLAG_W-1:0] yng_flags,
   output logic                  out_valid,
   output logic [LAT_W:0]        stall_cycles,
   output logic [HAZ_W-1:0]      hazard_kind
);

   if (NSRC < 1 || NDST < 1) begin : g_bad_cfg
      $error("pair_stall_calc: at least one source and one destination slot needed");
   end

   logic [NSRC-1:0] raw_hit;
   logic [NDST-1:0] waw_hit;
   logic [NSRC-1:0] war_hit;
   logic [LAT_W:0]  eff_lat;
   logic [LAT_W-1:0] wb_max;

   // older writes, younger reads
   stall_tag_match #(.NA(NDST), .NB(NSRC), .TAG_W(TAG_W)) u_raw (
      .a_vld (old_dst_vld), .a_tag (old_dst_tag),
      .b_vld (yng_src_vld), .b_tag (yng_src_tag),
      .b_hit (raw_hit)
   );

   // both write
   stall_tag_match #(.NA(NDST), .NB(NDST), .TAG_W(TAG_W)) u_waw (
      .a_vld (old_dst_vld), .a_tag (old_dst_tag),
      .b_vld (yng_dst_vld), .b_tag (yng_dst_tag),
      .b_hit (waw_hit)
   );

   // younger writes, older reads
   stall_tag_match #(.NA(NDST), .NB(NSRC), .TAG_W(TAG_W)) u_war (
      .a_vld (yng_dst_vld), .a_tag (yng_dst_tag),
      .b_vld (old_src_vld), .b_tag (old_src_tag),
      .b_hit (war_hit)
   );

   stall_lat_adjust #(.NDST(NDST), .LAT_W(LAT_W)) u_adj (
      .old_cls      (old_cls),
      .old_lat      (old_lat),
      .old_dst_vld  (old_dst_vld),
      .old_dst_wb   (old_dst_wb),
      .old_fpdst    (old_flags[OF_FPDST]),
      .yng_cls      (yng_cls),
      .yng_dbl      (yng_flags[YF_DBL]),
      .yng_fstore   (yng_flags[YF_FSTORE]),
      .yng_shreg    (yng_flags[YF_SHREG]),
      .raw_any      (|raw_hit),
      .raw_cnt_slot (raw_hit[0]),
      .eff_lat      (eff_lat),
      .wb_max       (wb_max)
   );

   stall_resolve #(.LAT_W(LAT_W), .WAR_VTRF(WAR_VTRF), .WAR_DBL(WAR_DBL)) u_res (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .raw_any      (|raw_hit),
      .eff_lat      (eff_lat),
      .waw_any      (|waw_hit),
      .wb_max       (wb_max),
      .war_any      (|war_hit),
      .old_cls      (old_cls),
      .old_dbl      (old_flags[OF_DBL]),
      .yng_cls      (yng_cls),
      .out_valid    (out_valid),
      .stall_cycles (stall_cycles),
      .hazard_kind  (hazard_kind)
   );

endmodule

// File: rtl/pair_stall_chk.sv
module pair_stall_chk
   import stall_pkg::*;
#(
   parameter int LAT_W    = 5,
   parameter int WAR_VTRF = 5,
   parameter int WAR_DBL  = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [CLS_W-1:0]      old_cls,
   input logic [OLD_FLAG_W-1:0] old_flags,
   input logic [CLS_W-1:0]      yng_cls,
   input logic                  out_valid,
   input logic [LAT_W:0]        stall_cycles,
   input logic [HAZ_W-1:0]      hazard_kind
);

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid)
      else $error("R1: request not answered in the next cycle");

   assert_idle_after_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && stall_cycles == '0 && hazard_kind == HZ_NONE))
      else $error("R1: outputs not idle after an empty cycle");

   assert_zero_means_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((stall_cycles == '0) == (hazard_kind == HZ_NONE)))
      else $error("R10: hazard code and zero stall disagree");

   assert_waw_pairing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hazard_kind == HZ_WAW) |-> $past(cls_is_fe(old_cls) && cls_is_ls(yng_cls)))
      else $error("R5: write-after-write reported for a pairing that excludes it");

   assert_war_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hazard_kind == HZ_WAR) |->
         (stall_cycles == (LAT_W+1)'(WAR_VTRF) || stall_cycles == (LAT_W+1)'(WAR_DBL)))
      else $error("R6: write-after-read stall has an unexpected value");

   assert_war_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hazard_kind == HZ_WAR) |->
         $past(old_cls == CLS_FVTRF || (old_cls == CLS_FARITH && old_flags[OF_DBL])))
      else $error("R6: write-after-read reported for an older class that never causes it");

endmodule

bind pair_stall_calc pair_stall_chk #(
   .LAT_W    (LAT_W),
   .WAR_VTRF (WAR_VTRF),
   .WAR_DBL  (WAR_DBL)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .old_cls      (old_cls),
   .old_flags    (old_flags),
   .yng_cls      (yng_cls),
   .out_valid    (out_valid),
   .stall_cycles (stall_cycles),
   .hazard_kind  (hazard_kind)
);

// File: tb/sim_pair_stall_calc.sv
`timescale 1ns/1ps
module sim_pair_stall_calc;
   import stall_pkg::*;

   localparam int NSRC  = 3;
   localparam int NDST  = 2;
   localparam int TAG_W = 5;
   localparam int LAT_W = 5;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic [CLS_W-1:0]      old_cls;
   logic [LAT_W-1:0]      old_lat;
   logic [NDST-1:0]       old_dst_vld;
   logic [NDST*TAG_W-1:0] old_dst_tag;
   logic [NDST*LAT_W-1:0] old_dst_wb;
   logic [NSRC-1:0]       old_src_vld;
   logic [NSRC*TAG_W-1:0] old_src_tag;
   logic [OLD_FLAG_W-1:0] old_flags;
   logic [CLS_W-1:0]      yng_cls;
   logic [NDST-1:0]       yng_dst_vld;
   logic [NDST*TAG_W-1:0] yng_dst_tag;
   logic [NSRC-1:0]       yng_src_vld;
   logic [NSRC*TAG_W-1:0] yng_src_tag;
   logic [YNG_FLAG_W-1:0] yng_flags;
   logic                  out_valid;
   logic [LAT_W:0]        stall_cycles;
   logic [HAZ_W-1:0]      hazard_kind;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      int    stall;
      int    kind;
      string req;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   pair_stall_calc #(.NSRC(NSRC), .NDST(NDST), .TAG_W(TAG_W), .LAT_W(LAT_W)) u0 (
      .clk, .rst_n, .in_valid,
      .old_cls, .old_lat, .old_dst_vld, .old_dst_tag, .old_dst_wb,
      .old_src_vld, .old_src_tag, .old_flags,
      .yng_cls, .yng_dst_vld, .yng_dst_tag, .yng_src_vld, .yng_src_tag, .yng_flags,
      .out_valid, .stall_cycles, .hazard_kind
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_fields();
      old_cls = CLS_INT;  old_lat = '0;
      old_dst_vld = '0;   old_dst_tag = '0; old_dst_wb = '0;
      old_src_vld = '0;   old_src_tag = '0; old_flags = '0;
      yng_cls = CLS_INT;
      yng_dst_vld = '0;   yng_dst_tag = '0;
      yng_src_vld = '0;   yng_src_tag = '0; yng_flags = '0;
   endtask

   task automatic o_dst(input int s, input int tag, input int wb);
      old_dst_vld[s] = 1'b1;
      old_dst_tag[s*TAG_W +: TAG_W] = TAG_W'(tag);
      old_dst_wb[s*LAT_W +: LAT_W]  = LAT_W'(wb);
   endtask

   task automatic o_src(input int s, input int tag);
      old_src_vld[s] = 1'b1;
      old_src_tag[s*TAG_W +: TAG_W] = TAG_W'(tag);
   endtask

   task automatic y_dst(input int s, input int tag);
      yng_dst_vld[s] = 1'b1;
      yng_dst_tag[s*TAG_W +: TAG_W] = TAG_W'(tag);
   endtask

   task automatic y_src(input int s, input int tag);
      yng_src_vld[s] = 1'b1;
      yng_src_tag[s*TAG_W +: TAG_W] = TAG_W'(tag);
   endtask

   // driver: fields were set by the caller at a falling edge
   task automatic send(input int exp_stall, input int exp_kind, input string req);
      exp_t e;
      e.stall = exp_stall; e.kind = exp_kind; e.req = req;
      sb.push_back(e);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      clear_fields();
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R1 unexpected result", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(int'(stall_cycles) == e.stall, {e.req, " stall"}, int'(stall_cycles), e.stall);
               check(int'(hazard_kind) == e.kind, {e.req, " kind"}, int'(hazard_kind), e.kind);
            end
         end else begin
            check(stall_cycles == '0 && hazard_kind == '0, "R1 idle outputs",
                  int'(stall_cycles), 0);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      clear_fields();
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && stall_cycles == '0 && hazard_kind == '0,
            "R1 reset state", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 plain read-after-write
      old_lat = 3; o_dst(0, 4, 3); y_src(1, 4);
      send(3, 1, "R2 raw base latency");
      // R11 invalid slots carrying equal tags
      old_lat = 3; o_dst(0, 9, 3); old_dst_tag[TAG_W +: TAG_W] = 5'd4;
      yng_src_tag[TAG_W +: TAG_W] = 5'd4; y_src(0, 12);
      send(0, 0, "R11 invalid slot ignored");
      // R3 divide: longest write-back 14 minus 1
      old_cls = CLS_FDIVSQ; old_lat = 10; o_dst(0, 2, 12); o_dst(1, 3, 14);
      yng_cls = CLS_MEM; y_dst(0, 2);
      send(13, 2, "R3 waw divide");
      // R4 other FP execute: 5 minus 2
      old_cls = CLS_FARITH; old_lat = 4; o_dst(0, 1, 5);
      yng_cls = CLS_LOAD; y_dst(0, 1);
      send(3, 2, "R4 waw fp arith");
      // R4 clamp: 2 minus 2 gives zero
      old_cls = CLS_FMISC; old_lat = 2; o_dst(0, 1, 2);
      yng_cls = CLS_MEM; y_dst(0, 1);
      send(0, 0, "R4 waw clamp");
      // R5 younger not load/store
      old_cls = CLS_FARITH; old_lat = 6; o_dst(0, 1, 6);
      yng_cls = CLS_INT; y_dst(0, 1);
      send(0, 0, "R5 younger integer");
      // R5 older not FP execute
      old_cls = CLS_INT; old_lat = 6; o_dst(0, 1, 6);
      yng_cls = CLS_MEM; y_dst(0, 1);
      send(0, 0, "R5 older integer");
      // R6 vector transform
      old_cls = CLS_FVTRF; old_lat = 4; o_src(1, 8);
      y_dst(0, 8);
      send(5, 3, "R6 war vector transform");
      // R6 double arithmetic
      old_cls = CLS_FARITH; old_lat = 8; old_flags[OF_DBL] = 1'b1; o_src(2, 9);
      y_dst(1, 9);
      send(2, 3, "R6 war double arith");
      // R6 single arithmetic gives nothing
      old_cls = CLS_FARITH; old_lat = 8; o_src(2, 9);
      y_dst(1, 9);
      send(0, 0, "R6 war single arith");
      // R7 FP result stored
      old_cls = CLS_FARITH; old_lat = 4; o_dst(0, 6, 4);
      yng_cls = CLS_MEM; yng_flags[YF_FSTORE] = 1'b1; y_src(0, 6);
      send(3, 1, "R7 store shortens");
      old_cls = CLS_FARITH; old_lat = 4; o_dst(0, 6, 4);
      yng_cls = CLS_MEM; y_src(0, 6);
      send(4, 1, "R7 no store flag");
      // R8 load feeding shift count
      old_cls = CLS_LOAD; old_lat = 2; o_dst(0, 7, 2);
      yng_flags[YF_SHREG] = 1'b1; y_src(0, 7);
      send(3, 1, "R8 shift count slot");
      old_cls = CLS_LOAD; old_lat = 2; o_dst(0, 7, 2);
      yng_flags[YF_SHREG] = 1'b1; y_src(1, 7);
      send(2, 1, "R8 other slot");
      // R9 short FP write into double/inner consumers
      old_lat = 1; old_flags[OF_FPDST] = 1'b1; o_dst(0, 3, 1);
      yng_cls = CLS_FARITH; yng_flags[YF_DBL] = 1'b1; y_src(0, 3);
      send(2, 1, "R9 double consumer");
      old_lat = 1; old_flags[OF_FPDST] = 1'b1; o_dst(0, 3, 1);
      yng_cls = CLS_FINNER; y_src(2, 3);
      send(2, 1, "R9 inner product");
      old_lat = 1; old_flags[OF_FPDST] = 1'b1; o_dst(0, 3, 1);
      yng_cls = CLS_FARITH; y_src(0, 3);
      send(1, 1, "R9 single consumer");
      old_lat = 1; o_dst(0, 3, 1);
      yng_cls = CLS_FARITH; yng_flags[YF_DBL] = 1'b1; y_src(0, 3);
      send(1, 1, "R9 no fp write");
      // R10 maximum across hazards and tie order
      old_cls = CLS_FVTRF; old_lat = 3; o_dst(0, 1, 3); o_src(0, 2);
      y_src(0, 1); y_dst(0, 2);
      send(5, 3, "R10 war wins");
      old_cls = CLS_FVTRF; old_lat = 5; o_dst(0, 1, 5); o_src(0, 2);
      y_src(0, 1); y_dst(0, 2);
      send(5, 1, "R10 tie goes to raw");

      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R1 all results seen", sb.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule